// File: doc/BRIEF.md
# Dual-Edge Clock Enable Generator

This block stands in for a slower clock without creating a new clock net. It runs on one fast system clock and emits two single-cycle strobes. The first marks the moments where a divided-down clock would rise. The second marks where that clock would fall. Downstream registers stay on the system clock and use these strobes as clock enables. Their logic then advances at the divided rate, with no new clock domain to constrain or cross.

One wrapping counter drives both strobes. The counter runs from zero to `DIV-1` and then returns to zero, so the virtual clock has a frequency of f_sys / `DIV`. For example, `DIV` = 2 on a 40 MHz clock gives 20 MHz. The falling strobe is tied to the top of the count. The rising strobe is tied to the programmable point `RISE_AT`. Its default, `DIV/2-1`, places the two strobes half a period apart, which gives a 50% duty cycle. The counter width is derived from `DIV`. An odd `DIV`, a `DIV` below 2, or a `RISE_AT` that does not lie below `DIV-1` stops elaboration with a fatal error. The factor is fixed when the block is built and cannot change at run time. Reset is synchronous and active high.

Top module: `cen_edge_gen`

## Requirements
- R1: Counting edges with reset low from k = 0 (the first such edge), `rise_en` is high in the cycle after edge k exactly when k mod `DIV` equals `RISE_AT`, and it is never high for two cycles in a row.
- R2: `fall_en` is high in the cycle after edge k exactly when k mod `DIV` equals `DIV-1`, so consecutive falling strobes are exactly `DIV` cycles apart.
- R3: With the default `RISE_AT`, a falling strobe follows a rising strobe after `DIV/2` cycles, and a rising strobe follows a falling strobe after `DIV/2` cycles.
- R4: While `rst` is high, and in the cycle after the last edge at which it was sampled high, both strobes are low; the count then restarts from zero.
- R5: `rise_en` and `fall_en` are never high in the same cycle.
- R6: With `DIV` = 2 and `RISE_AT` = 0, the strobes alternate every cycle, beginning with `rise_en` in the cycle after the first edge with reset low.
- R7: With a non-default compare point (`DIV` = 6, `RISE_AT` = 1), the rising strobe follows that point, while the falling strobe stays at count `DIV-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| rise_en | output | 1 | One-cycle strobe at each virtual rising edge |
| fall_en | output | 1 | One-cycle strobe at each virtual falling edge |

## Verification
Three builds are run side by side, with the default even split, the smallest legal factor, and a skewed compare point. Telling these apart shows whether a strobe follows its own compare value or a hard-wired one. Reset pulses of random length and at random places interrupt counting at every phase of the count. This exposes a counter that fails to restart at zero or a strobe that leaks out of reset. The spacing between strobes is measured from the observed outputs, not from the count. This separates a true half-period split from one that merely has the right frequency.

// File: rtl/cen_pkg.sv
package cen_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    function automatic int unsigned cnt_width(input int unsigned div);
        return (div < 3) ? 1 : $clog2(div);
    endfunction

    function automatic int unsigned match_point(input edge_kind_e kind,
                                                input int unsigned div,
                                                input int unsigned rise_at);
        return (kind == EDGE_RISE) ? rise_at : (div - 1);
    endfunction

endpackage

// File: rtl/cen_counter.sv
module cen_counter #(
    parameter int unsigned DIV = 8,
    parameter int unsigned W   = 3
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.count = '0;
        end else if (state_q.count == LAST) begin
            state_d.count = '0;
        end else begin
            state_d.count = state_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.count;
endmodule

// File: rtl/cen_match.sv
module cen_match #(
    parameter int unsigned W     = 3,
    parameter int unsigned POINT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count,
    output logic         pulse
);
    localparam logic [W-1:0] HIT = W'(POINT);

    typedef struct packed {
        logic pulse;
    } match_state_t;

    match_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pulse = 1'b0;
        end else begin
            state_d.pulse = (count == HIT);
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pulse = state_q.pulse;
endmodule

// File: rtl/cen_edge_gen.sv
module cen_edge_gen #(
    parameter int unsigned DIV     = 8,
    parameter int unsigned RISE_AT = DIV / 2 - 1
) (
    input  logic clk,
    input  logic rst,
    output logic rise_en,
    output logic fall_en
);
    import cen_pkg::*;

    localparam int unsigned W      = cnt_width(DIV);
    localparam int unsigned NEDGES = 2;

    if ((DIV % 2) != 0 || DIV < 2) begin : g_bad_div
        initial $fatal(1, "cen_edge_gen: DIV=%0d must be even and at least 2", DIV);
    end
    if (RISE_AT >= DIV - 1) begin : g_bad_rise
        initial $fatal(1, "cen_edge_gen: RISE_AT=%0d must lie below DIV-1", RISE_AT);
    end

    logic [W-1:0]      count;
    logic [NEDGES-1:0] strobes;

    cen_counter #(
        .DIV (DIV),
        .W   (W)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    for (genvar i = 0; i < NEDGES; i++) begin : g_edge
        localparam edge_kind_e KIND = (i == 0) ? EDGE_RISE : EDGE_FALL;
        cen_match #(
            .W     (W),
            .POINT (match_point(KIND, DIV, RISE_AT))
        ) u_match (
            .clk   (clk),
            .rst   (rst),
            .count (count),
            .pulse (strobes[i])
        );
    end

    assign rise_en = strobes[0];
    assign fall_en = strobes[1];
endmodule

// File: rtl/cen_edge_gen_chk.sv
module cen_edge_gen_chk #(
    parameter int unsigned DIV     = 8,
    parameter int unsigned RISE_AT = 3
) (
    input logic clk,
    input logic rst,
    input logic rise_en,
    input logic fall_en
);
    int   rise_age_q;
    int   fall_age_q;
    logic rise_seen_q;
    logic fall_seen_q;
    logic prev_rst_q;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
        if (rst) begin
            rise_age_q  <= 0;
            fall_age_q  <= 0;
            rise_seen_q <= 1'b0;
            fall_seen_q <= 1'b0;
        end else begin
            rise_age_q <= rise_en ? 1 : rise_age_q + 1;
            fall_age_q <= fall_en ? 1 : fall_age_q + 1;
            if (rise_en) rise_seen_q <= 1'b1;
            if (fall_en) fall_seen_q <= 1'b1;
        end
    end

    always @(posedge clk) begin
        if (prev_rst_q == 1'b1) begin
            AST_RESET_QUIET: assert (!rise_en && !fall_en); // R4
        end
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_en |=> !rise_en); // R1

    AST_FALL_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (fall_en && fall_seen_q) |-> (fall_age_q == int'(DIV))); // R2

    AST_RISE_TO_FALL: assert property (@(posedge clk) disable iff (rst)
        (fall_en && rise_seen_q) |-> (rise_age_q == int'(DIV - 1 - RISE_AT))); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(rise_en && fall_en)); // R5
endmodule

bind cen_edge_gen cen_edge_gen_chk #(
    .DIV     (DIV),
    .RISE_AT (RISE_AT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rise_en (rise_en),
    .fall_en (fall_en)
);

// File: tb/tb_cen_edge_gen.sv
module tb_cen_edge_gen;
    localparam int DIV_A  = 8;
    localparam int RISE_A = DIV_A / 2 - 1;
    localparam int DIV_B  = 2;
    localparam int RISE_B = 0;
    localparam int DIV_C  = 6;
    localparam int RISE_C = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rise_a, fall_a, rise_b, fall_b, rise_c, fall_c;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    int k = 0;
    int cyc = 0;
    int last_rise = -1;
    int last_fall = -1;

    always #2 clk = ~clk;

    cen_edge_gen #(.DIV(DIV_A)) dut (
        .clk(clk), .rst(rst), .rise_en(rise_a), .fall_en(fall_a));
    cen_edge_gen #(.DIV(DIV_B), .RISE_AT(RISE_B)) dut_min (
        .clk(clk), .rst(rst), .rise_en(rise_b), .fall_en(fall_b));
    cen_edge_gen #(.DIV(DIV_C), .RISE_AT(RISE_C)) dut_skew (
        .clk(clk), .rst(rst), .rise_en(rise_c), .fall_en(fall_c));

    function automatic bit exp_rise(input int idx, input int div, input int at);
        return (idx % div) == at;
    endfunction

    function automatic bit exp_fall(input int idx, input int div);
        return (idx % div) == (div - 1);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic step(input bit r);
        rst = r;
        @(negedge clk);
        cyc++;
        if (r) begin
            // R4: everything quiet right after a reset edge
            check("R4", "dut rise", rise_a, 0);
            check("R4", "dut fall", fall_a, 0);
            check("R4", "dut_min rise", rise_b, 0);
            check("R4", "dut_min fall", fall_b, 0);
            check("R4", "dut_skew rise", rise_c, 0);
            check("R4", "dut_skew fall", fall_c, 0);
            k = 0;
            last_rise = -1;
            last_fall = -1;
        end else begin
            check("R1", "dut rise", rise_a, exp_rise(k, DIV_A, RISE_A));
            check("R2", "dut fall", fall_a, exp_fall(k, DIV_A));
            check("R5", "dut overlap", rise_a & fall_a, 0);
            check("R6", "dut_min rise", rise_b, exp_rise(k, DIV_B, RISE_B));
            check("R6", "dut_min fall", fall_b, exp_fall(k, DIV_B));
            check("R5", "dut_min overlap", rise_b & fall_b, 0);
            check("R7", "dut_skew rise", rise_c, exp_rise(k, DIV_C, RISE_C));
            check("R7", "dut_skew fall", fall_c, exp_fall(k, DIV_C));
            check("R5", "dut_skew overlap", rise_c & fall_c, 0);
            // R3: measured spacing on the default instance
            if (fall_a && last_rise >= 0)
                check("R3", "rise-to-fall gap", cyc - last_rise, DIV_A / 2);
            if (rise_a && last_fall >= 0)
                check("R3", "fall-to-rise gap", cyc - last_fall, DIV_A / 2);
            if (rise_a) last_rise = cyc;
            if (fall_a) last_fall = cyc;
            k++;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        // directed: initial reset then a long run
        for (int i = 0; i < 3; i++) step(1'b1);
        for (int i = 0; i < 50; i++) step(1'b0);
        // directed: one-cycle reset mid-count
        step(1'b1);
        for (int i = 0; i < 20; i++) step(1'b0);
        // directed: reset right after a single run cycle
        step(1'b1);
        step(1'b0);
        step(1'b1);
        for (int i = 0; i < 17; i++) step(1'b0);
        // random reset placement and length
        for (int seg = 0; seg < 60; seg++) begin
            int run_len = 1 + int'($urandom % 40);
            int rst_len = 1 + int'($urandom % 3);
            for (int i = 0; i < rst_len; i++) step(1'b1);
            for (int i = 0; i < run_len; i++) step(1'b0);
        end
        finish_run();
    end
endmodule